// File: doc/BRIEF.md
# Wiper Tap Switch Sequencer

This block drives the switch array of a 256-position resistor ladder from an 8-bit wiper code and a sleep request. For each tap it produces one enable, raised when that tap connects to the wiper output. It also drives one enable for the switch that joins the top of the ladder to its high terminal, and one enable for the series path that parks the wiper on the low terminal.

A command carries a code and a sleep bit. These take effect only on a one-cycle update strobe, which marks the instant a command executes, normally the end of a serial transaction. When the wiper moves, the new tap closes for a set number of cycles before the old tap opens, so the wiper is never left floating. A command that arrives while a move is still in progress is held in the target registers and carried out once the current overlap ends. A sleep request opens the ladder and parks the wiper, always leaving a gap in which neither path is closed. The code stays stored through sleep and the tap it selects is reconnected on wake.

Top module: `wiper_tap_sequencer`

## Requirements
- R1: After reset, only tap enable bit 128 (code 80h) is high, the top-end enable is high and the park enable is low.
- R2: In steady operation exactly one tap enable is high, at bit index equal to the stored code. Bit 0 is the tap nearest the low terminal and bit 255 the tap nearest the high terminal.
- R3: A strobe with a new code at clock edge E0 gives both the old and the new tap enable high from edge E0+1 for exactly OVL_CYCLES cycles (default 4). After that only the new enable is high.
- R4: No more than two tap enables are ever high at the same time.
- R5: A strobe that arrives during an overlap is not lost. The wiper settles on the most recently strobed code.
- R6: A strobe that repeats the present code with the sleep bit clear causes no overlap and no change on any output.
- R7: A strobe with the sleep bit set turns off all tap enables and the top-end enable from edge E0+1. The park enable then stays low for GAP_CYCLES cycles (default 2) and rises at edge E0+1+GAP_CYCLES.
- R8: While parked, the park enable is high and the tap enables and top-end enable are low. Codes strobed during sleep are stored but connect no tap.
- R9: A strobe with the sleep bit clear while parked drops the park enable at E0+1. All enables are low for GAP_CYCLES cycles, after which the stored code's tap and the top-end enable rise.
- R10: Code and sleep inputs have no effect unless the update strobe is high.
- R11: The park enable and any tap enable are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wcode_i | input | 8 | Wiper code of the command |
| update_i | input | 1 | One-cycle strobe that executes the command |
| sleep_i | input | 1 | 1 requests sleep, 0 requests normal operation |
| tap_en_o | output | 256 | One enable per ladder tap, bit 0 at the low end |
| top_en_o | output | 1 | Connects the ladder top to the high terminal |
| park_en_o | output | 1 | Ties the wiper to the low terminal through the series path |

## Verification
The bench looks at the cycle in which each overlap begins and ends. A design that opens the old tap early, or keeps it closed too long, shows a count of tap enables that is wrong at a known sample. Strobes that land inside an overlap or inside a break gap are aimed at designs that drop a queued command or that close two paths at once. Such a design settles on a stale tap, or shows park and a tap high together. Group-boundary moves such as 0Fh to 10h, and codes strobed while asleep, catch a wrong split of the code into halves and a wake that restores the wrong tap.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_OVL     = 3'd1,
    ST_BRK_IN  = 3'd2,
    ST_PARK    = 3'd3,
    ST_BRK_OUT = 3'd4
  } seq_state_e;
endpackage

// File: rtl/wts_cmd_capture.sv
module wts_cmd_capture #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              update_i,
  input  logic [CODE_W-1:0] wcode_i,
  input  logic              sleep_i,
  output logic [CODE_W-1:0] tgt_code_o,
  output logic              tgt_sleep_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] code_d, code_q;
  logic              sleep_d, sleep_q;

  always_comb begin
    code_d  = code_q;
    sleep_d = sleep_q;
    if (update_i) begin
      code_d  = wcode_i;
      sleep_d = sleep_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= MID_CODE;
      sleep_q <= 1'b0;
    end else begin
      code_q  <= code_d;
      sleep_q <= sleep_d;
    end
  end

  // R10: targets move only on a strobe
  assert_hold_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(update_i) |-> $stable(code_q) && $stable(sleep_q));

  assign tgt_code_o  = code_q;
  assign tgt_sleep_o = sleep_q;
endmodule

// File: rtl/wts_tap_decoder.sv
module wts_tap_decoder #(
  parameter int HALF_W = 4
) (
  input  logic [2*HALF_W-1:0]      code_i,
  input  logic                     en_i,
  output logic [(1<<(2*HALF_W))-1:0] taps_o
);
  localparam int GROUPS = 1 << HALF_W;

  logic [GROUPS-1:0] grp_sel, pos_sel;

  always_comb begin
    grp_sel = '0;
    pos_sel = '0;
    if (en_i) begin
      grp_sel[code_i[2*HALF_W-1:HALF_W]] = 1'b1;
      pos_sel[code_i[HALF_W-1:0]]        = 1'b1;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar p = 0; p < GROUPS; p++) begin : g_pos
      assign taps_o[g*GROUPS + p] = grp_sel[g] & pos_sel[p];
    end
  end
endmodule

// File: rtl/wts_seq_fsm.sv
module wts_seq_fsm
  import wts_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int OVL_CYCLES = 4,
  parameter int GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_code_i,
  input  logic              tgt_sleep_i,
  output logic [CODE_W-1:0] cur_code_o,
  output logic [CODE_W-1:0] old_code_o,
  output logic              cur_on_o,
  output logic              old_on_o,
  output logic              top_en_o,
  output logic              park_en_o
);
  localparam int MAX_WIN = (OVL_CYCLES > GAP_CYCLES) ? OVL_CYCLES : GAP_CYCLES;
  localparam int CNT_W   = (MAX_WIN > 1) ? $clog2(MAX_WIN) : 1;
  localparam logic [CNT_W-1:0] OVL_LOAD = CNT_W'(OVL_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES - 1);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  seq_state_e        st_d, st_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q;
  logic [CODE_W-1:0] cur_d, cur_q, old_d, old_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cur_d = cur_q;
    old_d = old_q;
    unique case (st_q)
      ST_RUN: begin
        if (tgt_sleep_i) begin
          st_d  = ST_BRK_IN;
          cnt_d = GAP_LOAD;
        end else if (tgt_code_i != cur_q) begin
          st_d  = ST_OVL;
          old_d = cur_q;
          cur_d = tgt_code_i;
          cnt_d = OVL_LOAD;
        end
      end
      ST_OVL: begin
        if (cnt_q == '0) st_d = ST_RUN;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_BRK_IN: begin
        if (cnt_q == '0) st_d = ST_PARK;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_PARK: begin
        if (!tgt_sleep_i) begin
          st_d  = ST_BRK_OUT;
          cnt_d = GAP_LOAD;
        end
      end
      ST_BRK_OUT: begin
        if (cnt_q == '0) begin
          st_d  = ST_RUN;
          cur_d = tgt_code_i;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      cnt_q <= '0;
      cur_q <= MID_CODE;
      old_q <= MID_CODE;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cur_q <= cur_d;
      old_q <= old_d;
    end
  end

  assign cur_code_o = cur_q;
  assign old_code_o = old_q;
  assign cur_on_o   = (st_q == ST_RUN) || (st_q == ST_OVL);
  assign old_on_o   = (st_q == ST_OVL);
  assign top_en_o   = cur_on_o;
  assign park_en_o  = (st_q == ST_PARK);

  // R3: an overlap always joins two different taps
  assert_ovl_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OVL) |-> (old_q != cur_q));
  // R7: the park state is reached only through the entry break
  assert_park_after_break_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_PARK) |-> $past(st_q) == ST_BRK_IN);
  // R9: run resumes from park only through the exit break
  assert_wake_after_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN) && $past(st_q != ST_RUN) |-> $past(st_q) inside {ST_OVL, ST_BRK_OUT});
endmodule

// File: rtl/wiper_tap_sequencer.sv
module wiper_tap_sequencer #(
  parameter int HALF_W     = 4,
  parameter int OVL_CYCLES = 4,
  parameter int GAP_CYCLES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [2*HALF_W-1:0]         wcode_i,
  input  logic                        update_i,
  input  logic                        sleep_i,
  output logic [(1<<(2*HALF_W))-1:0]  tap_en_o,
  output logic                        top_en_o,
  output logic                        park_en_o
);
  localparam int CODE_W = 2 * HALF_W;
  localparam int TAPS   = 1 << CODE_W;

  logic [CODE_W-1:0] tgt_code, cur_code, old_code;
  logic              tgt_sleep, cur_on, old_on;
  logic [TAPS-1:0]   cur_taps, old_taps;

  wts_cmd_capture #(.CODE_W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .update_i(update_i), .wcode_i(wcode_i),
    .sleep_i(sleep_i), .tgt_code_o(tgt_code), .tgt_sleep_o(tgt_sleep)
  );

  wts_seq_fsm #(.CODE_W(CODE_W), .OVL_CYCLES(OVL_CYCLES), .GAP_CYCLES(GAP_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tgt_code_i(tgt_code), .tgt_sleep_i(tgt_sleep),
    .cur_code_o(cur_code), .old_code_o(old_code), .cur_on_o(cur_on),
    .old_on_o(old_on), .top_en_o(top_en_o), .park_en_o(park_en_o)
  );

  wts_tap_decoder #(.HALF_W(HALF_W)) u_dec_cur (
    .code_i(cur_code), .en_i(cur_on), .taps_o(cur_taps)
  );

  wts_tap_decoder #(.HALF_W(HALF_W)) u_dec_old (
    .code_i(old_code), .en_i(old_on), .taps_o(old_taps)
  );

  assign tap_en_o = cur_taps | old_taps;

  // R4: never more than two closed taps
  assert_two_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_en_o) <= 2);
  // R11: park path and tap switches never closed together
  assert_park_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    park_en_o |-> (tap_en_o == '0));
  // R2: outside an overlap a connected ladder has exactly one tap
  assert_single_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (top_en_o && !old_on) |-> $onehot(tap_en_o));
  // R8: parked means top end open
  assert_park_top_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    park_en_o |-> !top_en_o);
  // R7: park rises only after a cycle with no tap closed
  assert_park_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_en_o) |-> ($past(tap_en_o) == '0));
endmodule

// File: tb/wiper_tap_sequencer_test.sv
`timescale 1ns/1ps
module wiper_tap_sequencer_test;
  localparam int OVL = 4;
  localparam int GAP = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   wcode_i = 8'h00;
  logic         update_i = 1'b0;
  logic         sleep_i = 1'b0;
  logic [255:0] tap_en_o;
  logic         top_en_o, park_en_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wiper_tap_sequencer #(.HALF_W(4), .OVL_CYCLES(OVL), .GAP_CYCLES(GAP)) uut (
    .clk(clk), .rst_n(rst_n), .wcode_i(wcode_i), .update_i(update_i),
    .sleep_i(sleep_i), .tap_en_o(tap_en_o), .top_en_o(top_en_o), .park_en_o(park_en_o)
  );

  function automatic logic [255:0] tap_of(input logic [7:0] c);
    return 256'b1 << c;
  endfunction

  task automatic chk_vec(input string req, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive a strobe at a negedge; returns at the negedge after edge E0
  task automatic strobe(input logic [7:0] c, input logic s);
    wcode_i = c; sleep_i = s; update_i = 1'b1;
    cyc(1);
    update_i = 1'b0;
  endtask

  task automatic chk_steady(input string req, input logic [7:0] c);
    chk_vec(req, tap_en_o, tap_of(c));
    chk_bit(req, top_en_o, 1'b1);
    chk_bit(req, park_en_o, 1'b0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] last_c;
    logic       last_s;
    void'($urandom(32'd7741));
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk_steady("R1", 8'h80);

    // R10: inputs without strobe do nothing
    wcode_i = 8'h11; sleep_i = 1'b1;
    cyc(6);
    chk_steady("R10", 8'h80);
    sleep_i = 1'b0;

    // R3: make before break 80h -> 0Fh
    strobe(8'h0F, 1'b0);
    chk_steady("R3 pre", 8'h80);
    cyc(1);
    chk_vec("R3 first", tap_en_o, tap_of(8'h80) | tap_of(8'h0F));
    cyc(OVL - 1);
    chk_vec("R3 last", tap_en_o, tap_of(8'h80) | tap_of(8'h0F));
    cyc(1);
    chk_steady("R3 after", 8'h0F);

    // R2: group boundary 0Fh -> 10h
    strobe(8'h10, 1'b0);
    cyc(1 + OVL + 2);
    chk_steady("R2 boundary", 8'h10);
    strobe(8'h00, 1'b0); cyc(OVL + 3);
    chk_steady("R2 low end", 8'h00);
    strobe(8'hFF, 1'b0); cyc(OVL + 3);
    chk_steady("R2 high end", 8'hFF);

    // R6: same code gives no overlap
    strobe(8'hFF, 1'b0);
    cyc(1);
    chk_steady("R6", 8'hFF);
    cyc(2);
    chk_steady("R6 later", 8'hFF);

    // R5: strobe inside overlap is queued
    strobe(8'h33, 1'b0);
    cyc(2);
    strobe(8'hC5, 1'b0);
    cyc(3 * OVL + 6);
    chk_steady("R5", 8'hC5);

    // R7: sleep entry
    strobe(8'hC5, 1'b1);
    cyc(1);
    chk_vec("R7 taps", tap_en_o, '0);
    chk_bit("R7 top", top_en_o, 1'b0);
    chk_bit("R7 park gap", park_en_o, 1'b0);
    cyc(GAP - 1);
    chk_bit("R7 park gap end", park_en_o, 1'b0);
    cyc(1);
    chk_bit("R7 park on", park_en_o, 1'b1);

    // R8: code strobed while asleep is stored only
    strobe(8'h2A, 1'b1);
    cyc(4);
    chk_vec("R8 taps", tap_en_o, '0);
    chk_bit("R8 park", park_en_o, 1'b1);
    chk_bit("R8 top", top_en_o, 1'b0);

    // R9: wake restores stored code
    strobe(8'h2A, 1'b0);
    cyc(1);
    chk_bit("R9 park off", park_en_o, 1'b0);
    chk_vec("R9 gap taps", tap_en_o, '0);
    cyc(GAP - 1);
    chk_vec("R9 gap end", tap_en_o, '0);
    cyc(1);
    chk_steady("R9 restore", 8'h2A);

    // random phase: R4, R11 every cycle, R5 convergence at end
    last_c = 8'h2A; last_s = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(2, 0) == 0) begin
        wcode_i = 8'($urandom_range(255, 0));
        sleep_i = ($urandom_range(9, 0) == 0);
        update_i = 1'b1;
        last_c = wcode_i; last_s = sleep_i;
      end else begin
        update_i = 1'b0;
        wcode_i = 8'($urandom_range(255, 0));
        sleep_i = $urandom_range(1, 0) == 1;
      end
      cyc(1);
      if ($countones(tap_en_o) > 2) chk_bit("R4 random", 1'b0, 1'b1);
      if (park_en_o && (tap_en_o != '0)) chk_bit("R11 random", 1'b0, 1'b1);
    end
    update_i = 1'b0;
    total += 2;
    cyc(40);
    if (last_s) begin
      chk_vec("R5 random final sleep", tap_en_o, '0);
      chk_bit("R8 random final park", park_en_o, 1'b1);
    end else begin
      chk_steady("R5 random final", last_c);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule